// File: doc/BRIEF.md
# Longword Instruction Cache

This block is a read-only instruction cache placed between a processor's opcode fetch port and an external memory bus. It holds 64 independent 32-bit entries, each carrying its own tag and valid bit. Each entry holds two 16-bit opcode words. A fetch names a halfword address and a privilege bit. When the indexed entry is valid and its tag and privilege bit both match, the requested word comes back in the same cycle and the bus stays idle. On a miss the cache reads the aligned longword around the address, stores all of it in the entry and hands the requested half to the processor.

Both sides use a valid/ready handshake. On the fetch side the processor raises `fch_valid` and holds `fch_addr` and `fch_fc` steady until `fch_ready` is high. A word is accepted in any cycle where both signals are high. On the memory side the cache raises `mem_req` and holds `mem_addr` steady until the bus answers with `mem_ready`. The bus may stall for any number of cycles, and `mem_rdata` is sampled in the cycle where `mem_ready` is high. `cache_off` turns the cache off for lookup and refill. `inv_all` empties the cache in one cycle.

Top module: `icache_lw`

## Requirements
- R1: After reset no entry is valid, and with `fch_valid` low both `fch_ready` and `mem_req` are low.
- R2: A fetch hits when the entry selected by address bits 7..2 is valid, its stored address bits 31..8 equal the request's, and its stored privilege bit equals `fch_fc`. A hit raises `fch_ready` in the request cycle and leaves `mem_req` low.
- R3: Address bit 1 picks the half of the longword. Bit 1 = 0 returns bits 31..16, and bit 1 = 1 returns bits 15..0. This holds for hits and for words forwarded from the bus.
- R4: On a miss, `mem_req` rises in the cycle after the request, with `mem_addr` equal to request address bits 31..2. `fch_ready` is high exactly in the cycle where `mem_ready` is high, and it carries the selected half of `mem_rdata`.
- R5: A refill stores the whole longword. After a miss on either word, a fetch of the other word of that longword hits.
- R6: An entry filled with one privilege bit misses for a fetch with the other bit value.
- R7: Two addresses that differ by a multiple of 256 bytes share an entry. Fetching one evicts the other.
- R8: While `cache_off` is high, every fetch is served from memory, valid entries are not used, and no entry is written.
- R9: A cycle with `inv_all` high clears every valid bit. If a refill completes in that same cycle, it does not make its entry valid.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_req` stays high and `mem_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cache_off | input | 1 | Disables lookup and refill writes |
| inv_all | input | 1 | Clears all valid bits this cycle |
| fch_valid | input | 1 | Fetch request valid |
| fch_addr | input | ADDR_W-1 | Halfword address, byte address bits 31..1 |
| fch_fc | input | 1 | Privilege bit, part of the tag |
| fch_ready | output | 1 | Fetch word delivered this cycle |
| fch_data | output | 16 | Opcode word |
| mem_req | output | 1 | Bus read request |
| mem_addr | output | ADDR_W-2 | Longword address, byte address bits 31..2 |
| mem_ready | input | 1 | Bus data valid this cycle |
| mem_rdata | input | 32 | Bus read data |

## Verification
The bench walks all 64 entries. It misses on one word and then expects a hit on the other, with bus latencies from zero to several cycles. A design that refilled only half a longword, or swapped the halves, would return wrong words there. A design that stalled badly would be off in its counted ready cycle. The bench then runs aliasing at a 256-byte distance and flips the privilege bit. A design that dropped tag bits or the privilege bit would report false hits carrying the other address's data. The bench also drives `cache_off`, an idle invalidate, and an invalidate in the same cycle as a refill. A design that wrote entries while disabled, or let a refill win over the invalidate, would hit where a miss is required.

// File: rtl/icl_pkg.sv
`timescale 1ns/100ps
package icl_pkg;
  localparam int HALF_W = 16;
  localparam int LONG_W = 32;

  typedef enum logic {ST_IDLE, ST_FILL} icl_state_e;

  // bit 1 of the byte address: 0 -> high half, 1 -> low half
  function automatic logic [HALF_W-1:0] pick_half(input logic [LONG_W-1:0] lw, input logic lo);
    return lo ? lw[HALF_W-1:0] : lw[LONG_W-1:HALF_W];
  endfunction
endpackage

// File: rtl/icl_store.sv
`timescale 1ns/100ps
module icl_store #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 25
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inv_all,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic                       rd_valid,
  output logic [TAG_W-1:0]           rd_tag,
  output logic [icl_pkg::LONG_W-1:0] rd_data,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic [icl_pkg::LONG_W-1:0] wr_data
);
  logic [ENTRIES-1:0]         valid_q;
  logic [TAG_W-1:0]           tag_q  [ENTRIES];
  logic [icl_pkg::LONG_W-1:0] data_q [ENTRIES];

  // invalidate wins over a same-cycle fill
  always_ff @(posedge clk) begin
    if (rst || inv_all) valid_q <= '0;
    else if (wr_en)     valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/icl_lookup.sv
`timescale 1ns/100ps
module icl_lookup #(
  parameter int TAG_W = 25
) (
  input  logic                       cache_off,
  input  logic                       ent_valid,
  input  logic [TAG_W-1:0]           ent_tag,
  input  logic [icl_pkg::LONG_W-1:0] ent_data,
  input  logic [TAG_W-1:0]           req_tag,
  input  logic                       req_lo,
  output logic                       hit,
  output logic [icl_pkg::HALF_W-1:0] word
);
  assign hit  = ent_valid && (ent_tag == req_tag) && !cache_off;
  assign word = icl_pkg::pick_half(ent_data, req_lo);
endmodule

// File: rtl/icl_fill_ctl.sv
`timescale 1ns/100ps
module icl_fill_ctl #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cache_off,
  input  logic              inv_all,
  input  logic              fch_valid,
  input  logic [ADDR_W-1:1] fch_addr,
  input  logic              fch_fc,
  input  logic              hit,
  input  logic              mem_ready,
  output logic              busy,
  output logic              fill_we,
  output logic [ADDR_W-1:1] fill_addr,
  output logic              fill_fc
);
  import icl_pkg::*;
  icl_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      fill_addr <= '0;
      fill_fc   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (fch_valid && !hit) begin
          state_q   <= ST_FILL;
          fill_addr <= fch_addr;
          fill_fc   <= fch_fc;
        end
        ST_FILL: if (mem_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state_q == ST_FILL);
  assign fill_we = busy && mem_ready && !cache_off && !inv_all;
endmodule

// File: rtl/icache_lw.sv
`timescale 1ns/100ps
module icache_lw #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cache_off,
  input  logic              inv_all,
  input  logic              fch_valid,
  input  logic [ADDR_W-1:1] fch_addr,
  input  logic              fch_fc,
  output logic              fch_ready,
  output logic [15:0]       fch_data,
  output logic              mem_req,
  output logic [ADDR_W-1:2] mem_addr,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - 2 + 1;

  logic [IDX_W-1:0]  req_idx, wr_idx;
  logic [TAG_W-1:0]  req_tag, wr_tag, ent_tag;
  logic [31:0]       ent_data;
  logic [15:0]       hit_word;
  logic              ent_valid, hit, busy, fill_we, fill_fc;
  logic [ADDR_W-1:1] fill_addr;

  assign req_idx = fch_addr[IDX_W+1:2];
  assign req_tag = {fch_fc, fch_addr[ADDR_W-1:IDX_W+2]};
  assign wr_idx  = fill_addr[IDX_W+1:2];
  assign wr_tag  = {fill_fc, fill_addr[ADDR_W-1:IDX_W+2]};

  icl_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst), .inv_all(inv_all),
    .rd_idx(req_idx), .rd_valid(ent_valid), .rd_tag(ent_tag), .rd_data(ent_data),
    .wr_en(fill_we), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(mem_rdata)
  );

  icl_lookup #(.TAG_W(TAG_W)) u_look (
    .cache_off(cache_off), .ent_valid(ent_valid), .ent_tag(ent_tag),
    .ent_data(ent_data), .req_tag(req_tag), .req_lo(fch_addr[1]),
    .hit(hit), .word(hit_word)
  );

  icl_fill_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst(rst), .cache_off(cache_off), .inv_all(inv_all),
    .fch_valid(fch_valid), .fch_addr(fch_addr), .fch_fc(fch_fc), .hit(hit),
    .mem_ready(mem_ready), .busy(busy), .fill_we(fill_we),
    .fill_addr(fill_addr), .fill_fc(fill_fc)
  );

  assign mem_req   = busy;
  assign mem_addr  = fill_addr[ADDR_W-1:2];
  assign fch_ready = busy ? mem_ready : (fch_valid && hit);
  assign fch_data  = busy ? icl_pkg::pick_half(mem_rdata, fill_addr[1]) : hit_word;
endmodule

// File: rtl/icache_lw_chk.sv
`timescale 1ns/100ps
module icache_lw_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cache_off,
  input logic              inv_all,
  input logic              fch_valid,
  input logic              fch_ready,
  input logic              mem_req,
  input logic [ADDR_W-1:2] mem_addr,
  input logic              mem_ready
);
  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R4
  fill_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (fch_ready && mem_req) |-> mem_ready);

  // R2
  req_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(fch_valid && !fch_ready));

  // R8
  off_nohit_chk: assert property (@(posedge clk) disable iff (rst)
    cache_off |-> !(fch_ready && !mem_req));

  // R9
  inv_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $past(inv_all) |-> !(fch_valid && fch_ready && !mem_req));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fch_ready && !mem_req) |-> fch_valid);
endmodule

bind icache_lw icache_lw_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cache_off(cache_off), .inv_all(inv_all),
  .fch_valid(fch_valid), .fch_ready(fch_ready), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/sim_icache_lw.sv
`timescale 1ns/100ps
module sim_icache_lw;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cache_off = 1'b0, inv_all = 1'b0;
  logic        fch_valid = 1'b0, fch_fc = 1'b0;
  logic [31:1] fch_addr = '0;
  logic        fch_ready, mem_req, mem_ready = 1'b0;
  logic [15:0] fch_data;
  logic [31:2] mem_addr;
  logic [31:0] mem_rdata = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  icache_lw u0 (.*);

  function automatic logic [31:0] mdata(input logic [31:0] a, input logic fc);
    return ({2'b00, a[31:2]} * 32'h9E3779B1) ^ (fc ? 32'h5A5A0000 : 32'h0) ^ 32'h0F0F1234;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one fetch; memory answers after lat wait cycles; inv_mid pulses inv_all with the answer
  task automatic fetch(input logic [31:0] a, input logic fc, input int lat,
                       input bit exp_mem, input string req, input bit inv_mid);
    int cyc = 0, w = 0;
    bit used = 0, got = 0;
    logic [15:0] d = '0;
    logic [31:0] m = mdata(a, fc);
    @(negedge clk);
    fch_valid = 1'b1; fch_addr = a[31:1]; fch_fc = fc; mem_ready = 1'b0;
    while (!got && cyc < 40) begin
      #0.4;
      if (mem_req) begin
        if (!used) chk(mem_addr == a[31:2], req, {mem_addr, 2'b00}, {a[31:2], 2'b00});
        used = 1;
        if (w >= lat) begin
          mem_ready = 1'b1; mem_rdata = m;
          if (inv_mid) inv_all = 1'b1;
        end
        w++;
      end
      #0.4;
      if (fch_ready) begin d = fch_data; got = 1; end
      else begin @(negedge clk); cyc++; end
    end
    chk(got, req, 32'(cyc), 32'(exp_mem ? 1 + lat : 0));
    chk(used == exp_mem, req, 32'(used), 32'(exp_mem));
    chk(cyc == (exp_mem ? 1 + lat : 0), req, 32'(cyc), 32'(exp_mem ? 1 + lat : 0));
    chk(d == (a[1] ? m[15:0] : m[31:16]), req, 32'(d), 32'(a[1] ? m[15:0] : m[31:16]));
    @(negedge clk);
    fch_valid = 1'b0; mem_ready = 1'b0; inv_all = 1'b0;
  endtask

  localparam logic [31:0] BASE = 32'h0001_0000;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #0.8;
    // R1: quiet after reset
    chk(!fch_ready && !mem_req, "R1", {fch_ready, mem_req}, 0);
    fetch(BASE, 1'b0, 0, 1, "R1", 0);
    // R5, R3, R4: odd word misses, even word of the same longword hits
    for (int i = 0; i < 64; i++) begin
      fetch(BASE + 32'(4 * i) + 2, 1'b0, i % 4, i != 0, "R4", 0);
      fetch(BASE + 32'(4 * i), 1'b0, 0, 0, "R5", 0);
      fetch(BASE + 32'(4 * i) + 2, 1'b0, 0, 0, "R3", 0);
    end
    // R7: alias at +256 evicts, then original misses again
    for (int i = 0; i < 64; i += 9) begin
      fetch(BASE + 32'h100 + 32'(4 * i), 1'b0, 1, 1, "R7", 0);
      fetch(BASE + 32'(4 * i), 1'b0, 0, 1, "R7", 0);
      fetch(BASE + 32'(4 * i) + 2, 1'b0, 0, 0, "R2", 0);
    end
    // R6: privilege bit is part of the tag
    fetch(BASE + 32'h20, 1'b1, 2, 1, "R6", 0);
    fetch(BASE + 32'h22, 1'b1, 0, 0, "R6", 0);
    fetch(BASE + 32'h20, 1'b0, 0, 1, "R6", 0);
    // R8: disabled cache ignores resident entries and writes none
    cache_off = 1'b1;
    fetch(BASE + 32'h40, 1'b0, 0, 1, "R8", 0);
    fetch(BASE + 32'h4000, 1'b0, 1, 1, "R8", 0);
    cache_off = 1'b0;
    fetch(BASE + 32'h4000, 1'b0, 0, 1, "R8", 0);
    fetch(BASE + 32'h4002, 1'b0, 0, 0, "R8", 0);
    // R9: idle invalidate
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    fetch(BASE + 32'h44, 1'b0, 0, 1, "R9", 0);
    // R9: invalidate in the refill cycle wins
    fetch(BASE + 32'h80, 1'b0, 2, 1, "R9", 1);
    fetch(BASE + 32'h82, 1'b0, 0, 1, "R9", 0);
    fetch(BASE + 32'h80, 1'b0, 0, 0, "R9", 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=1 exp=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule